// File: doc/BRIEF.md
# Streaming Serial Bit-Reversal Buffer

This block takes an unbroken serial stream of words, grouped into frames of 2^M words, and sends each frame out again with its word order permuted by index bit reversal. Word k of an output frame is word r(k) of the frame received before it. Here r(k) is k with its M index bits in the opposite order, so bit b of k becomes bit M-1-b. A typical user is the output stage of a streaming FFT whose results come out in reversed index order.

The block holds one storage array of exactly one frame. Every accepted word reads the old word at an address and writes the new word to the same address in the same cycle. In even frames the address is the in-frame index. In odd frames it is that index with its bits reversed. Because the order flips each frame, every location is freed just as it is reused, so the block needs no second bank and no data multiplexers. The word count M and the data width are parameters.

A start strobe marks word 0 of a frame and restarts the sequence. Holding the valid input low pauses the stream.

Top module: `brev_stream_buf`

## Requirements
- R1: While reset is high and in the cycle after reset, out_valid is 0. The first word accepted after reset, with or without in_start, is index 0 of a frame stored in natural order. The second frame after reset therefore comes out as the first frame in bit-reversed order.
- R2: out_valid stays 0 for the first 2^M words accepted after reset or after a start word.
- R3: Once a full frame has been accepted, each accepted word that is not a start word makes out_valid 1 exactly one cycle later.
- R4: Output word k of a frame equals input word r(k) of the previous input frame, where r(k) reverses the M index bits of k.
- R5: R4 holds for several frames in a row. This covers frames stored in natural order and frames stored in reversed order.
- R6: A cycle with in_valid 0 writes nothing and does not advance the index. out_valid is 0 and out_data keeps its value in the following cycle. The stream then continues unchanged.
- R7: An accepted word with in_start 1 becomes index 0 of a new frame in natural order. Partly buffered data is dropped, and out_valid is 0 for the next 2^M accepted words.
- R8: On a gap-free stream, the first output word appears 2^M + 1 cycles after the first input word of the stream. That is 2^M words of storage plus one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present this cycle |
| in_start | input | 1 | With in_valid: this word is index 0 of a new frame |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | out_data holds a reordered word |
| out_data | output | DATA_W | Reordered output word |

## Verification
The bench runs more than four frames back to back with distinct counting data, so both address orders are exercised. A design that failed to flip the order, or that read after writing, would return the wrong frame or the wrong index. Idle cycles carry a junk value on in_data. A stall that wrote or advanced the index would shift or corrupt every later word. A restart in the middle of a frame, and a reset in the middle of the stream without a start word, check that the index and the fill state return to zero. A design that kept stale state would raise out_valid too early or emit data from the wrong frame. The first output cycle is checked exactly, which catches a latency that is one cycle off.

// File: rtl/brev_pkg.sv
package brev_pkg;

    typedef enum logic {
        ORD_NATURAL  = 1'b0,
        ORD_REVERSED = 1'b1
    } addr_order_e;

    typedef struct packed {
        logic        accept;
        logic        emit;
        addr_order_e order;
    } slot_ctrl_t;

endpackage

// File: rtl/brev_addr_gen.sv
module brev_addr_gen
    import brev_pkg::*;
#(
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_start,
    output logic [M-1:0] addr,
    output slot_ctrl_t   ctrl
);
    logic [M:0]   cnt_q;
    logic         primed_q;
    logic [M:0]   base;
    logic [M-1:0] lin;
    logic [M-1:0] rev;

    // A start word is treated as if the counter were already zero.
    assign base = in_start ? '0 : cnt_q;
    assign lin  = base[M-1:0];

    for (genvar i = 0; i < M; i++) begin : g_rev
        assign rev[i] = lin[M-1-i];
    end

    always_comb begin
        ctrl.accept = in_valid;
        ctrl.emit   = in_valid && !in_start && primed_q;
        ctrl.order  = base[M] ? ORD_REVERSED : ORD_NATURAL;
        addr        = (ctrl.order == ORD_REVERSED) ? rev : lin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            primed_q <= 1'b0;
        end else if (in_valid) begin
            cnt_q    <= base + (M+1)'(1);
            primed_q <= (primed_q && !in_start) || (&lin);
        end
    end

endmodule

// File: rtl/brev_store.sv
module brev_store #(
    parameter int W = 16,
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         we,
    input  logic [M-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    localparam int DEPTH = 1 << M;

    logic [W-1:0] mem [DEPTH];

    // The old word is read and the new word is written at the same address.
    always_ff @(posedge clk) begin
        if (we) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/brev_stream_buf.sv
module brev_stream_buf
    import brev_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int M      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [M-1:0] slot_addr;
    slot_ctrl_t   ctrl;

    brev_addr_gen #(.M(M)) addr_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_start (in_start),
        .addr     (slot_addr),
        .ctrl     (ctrl)
    );

    brev_store #(.W(DATA_W), .M(M)) store_i (
        .clk   (clk),
        .we    (ctrl.accept),
        .addr  (slot_addr),
        .wdata (in_data),
        .rdata (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= ctrl.emit;
    end

endmodule

// File: rtl/brev_stream_chk.sv
module brev_stream_chk #(
    parameter int DATA_W = 16,
    parameter int M      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_start,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int NW = 1 << M;
    localparam int CW = $clog2(NW + 1);

    // Words accepted since reset or since the last start word, saturating at one frame.
    logic [CW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst)                             fill_q <= '0;
        else if (in_valid && in_start)       fill_q <= CW'(1);
        else if (in_valid && fill_q != CW'(NW)) fill_q <= fill_q + CW'(1);
    end

    p_fill_before_out_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(fill_q) == CW'(NW)));

    p_emit_when_full_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_start && fill_q == CW'(NW)) |=> out_valid);

    p_stall_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    p_start_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start) |=> !out_valid);

endmodule

bind brev_stream_buf brev_stream_chk #(.DATA_W(DATA_W), .M(M)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/brev_stream_buf_tb.sv
`timescale 1ns/1ps
module brev_stream_buf_tb_top;
    localparam int M  = 4;
    localparam int NW = 1 << M;
    localparam int W  = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_start = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    always #5 clk = ~clk;

    brev_stream_buf #(.DATA_W(W), .M(M)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct {
        logic         v;
        logic [W-1:0] d;
        string        tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model of the stream
    logic [W-1:0] prev_f [NW];
    logic [W-1:0] cur_f  [NW];
    int idx = 0;
    bit primed = 0;

    function automatic int brev_idx(int k);
        int r = 0;
        for (int b = 0; b < M; b++)
            if (k[b]) r = r | (1 << (M - 1 - b));
        return r;
    endfunction

    function automatic logic [W-1:0] word_of(int f, int i);
        return W'(16'h0100 + f * NW + i);
    endfunction

    task automatic cycle(bit v, bit s, logic [W-1:0] d, string tag);
        exp_t e;
        in_valid = v;
        in_start = s;
        in_data  = d;
        e.v = 1'b0;
        e.d = '0;
        e.tag = tag;
        if (v) begin
            if (s) begin
                idx = 0;
                primed = 0;
            end
            if (primed) begin
                e.v = 1'b1;
                e.d = prev_f[brev_idx(idx)];
            end
            cur_f[idx] = d;
            idx++;
            if (idx == NW) begin
                prev_f = cur_f;
                idx = 0;
                primed = 1;
            end
        end
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_start = 1'b0;
        idx = 0;
        primed = 0;
        repeat (2) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: out_valid in reset=%0b expected 0", out_valid);
        end
        rst = 1'b0;
    endtask

    // Monitor: one expected entry per driven cycle, compared after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                total++;
                if (out_valid !== e.v) begin
                    bad++;
                    $display("FAIL %s: out_valid=%0b expected %0b", e.tag, out_valid, e.v);
                end else if (e.v) begin
                    total++;
                    if (out_data !== e.d) begin
                        bad++;
                        $display("FAIL %s: out_data=%h expected %h", e.tag, out_data, e.d);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2, R8, R4, R5, R3: back-to-back frames
        for (int f = 0; f < 5; f++) begin
            for (int i = 0; i < NW; i++) begin
                string t;
                if (f == 0)                t = "R2";
                else if (f == 1 && i == 0) t = "R8";
                else if (f == 1)           t = "R4";
                else if (f == 3)           t = "R3";
                else                       t = "R5";
                cycle(1'b1, (f == 0 && i == 0), word_of(f, i), t);
            end
        end

        // R6: stalls with junk data between words
        for (int i = 0; i < NW; i++) begin
            if (i % 3 == 1) cycle(1'b0, 1'b0, 16'hDEAD, "R6");
            cycle(1'b1, 1'b0, word_of(5, i), "R6");
        end

        // R7: restart part way through a frame
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, word_of(6, i), "R5");
        for (int f = 7; f < 9; f++)
            for (int i = 0; i < NW; i++)
                cycle(1'b1, (f == 7 && i == 0), word_of(f, i), "R7");
        for (int i = 0; i < NW; i++) cycle(1'b1, 1'b0, word_of(9, i), "R4");

        // R1: reset mid-stream, then stream without a start word
        do_reset();
        for (int f = 10; f < 12; f++)
            for (int i = 0; i < NW; i++)
                cycle(1'b1, 1'b0, word_of(f, i), "R1");

        repeat (3) cycle(1'b0, 1'b0, 16'hBEEF, "R6");
        @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule